// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator machine. A microcode store inside the block holds one horizontal word per control step: a bit for each control line, a condition selector and a target address. A control address register names the word to be read, and the word is latched into a control buffer register whose line bits drive the datapath for exactly one clock. The next address comes from the word's sequencing fields. It is either the following address, a jump inside the current routine, or a jump to another routine: fetch, indirect, interrupt, or the start address of the routine for the current opcode.

The datapath drives the opcode, the indirect bit, the interrupt request and the ALU flags back into the block. The block returns the control vector. The bus read and bus write strobes are part of that vector. There is no data stream, so every pin is a plain level.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, `ctrl_o` is all zero and `car_o` is 0. The first clock edge after release puts the first fetch step on the outputs.
- R2: Each control line has a fixed bit in `ctrl_o`. Bit 0 copies PC to MAR. Bit 1 loads MBR from memory. Bit 2 increments PC. Bit 3 loads IR from MBR. Bit 4 copies the IR address to MAR. Bit 5 copies the MBR address field into the IR address field. Bit 6 copies PC to MBR. Bit 7 loads the save address into MAR. Bit 8 loads the handler address into PC. Bit 9 writes MBR to memory. Bit 10 is the bus read strobe. Bit 11 is the bus write strobe. Bit 12 adds MBR into the accumulator. Bit 13 loads the accumulator from MBR. Bit 14 copies the accumulator to MBR. Bit 15 copies the IR address to PC. One word is active per clock.
- R3: Fetch sits at address 0 and runs for three clocks: {0}, then {1,2,10}, then {3}.
- R4: In the last fetch step, `ind_i` high sends control to indirect at address 4. Otherwise control goes to the routine for `opcode_i`.
- R5: Indirect runs for three clocks: {4}, then {1,10}, then {5}. It then goes to the routine for `opcode_i`.
- R6: Interrupt sits at address 8 and runs for three clocks: {6}, then {7,8}, then {9,11}. It then returns to fetch.
- R7: The last step of each defined opcode routine goes to interrupt when `irq_i` is high, and to fetch when it is low. `irq_i` has no effect in any other step.
- R8: Opcode 0 is a single idle word. Opcode 1 loads the accumulator: {4}, {1,10}, {13}. Opcode 2 adds: {4}, {1,10}, {12}. Opcode 3 stores: {4}, {14}, {9,11}. Opcode 4 jumps: {15}.
- R9: Opcodes 5, 6 and 7 each test one flag in an idle word: `zero_i`, `neg_i` and `carry_i` respectively. If the flag is set, control jumps inside the routine to a word that drives {15}. If it is clear, control falls through to a second idle word.
- R10: Opcodes 8 to 15 run a single idle word and return straight to fetch, whatever the level of `irq_i`.
- R11: The bus read and bus write strobes are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Opcode of the instruction being run |
| ind_i | input | 1 | Indirect-addressing bit of that instruction |
| irq_i | input | 1 | Interrupt pending |
| zero_i | input | 1 | ALU zero flag |
| neg_i | input | 1 | ALU negative flag |
| carry_i | input | 1 | ALU carry flag |
| ctrl_o | output | 16 | Horizontal control vector (bit map in R2) |
| car_o | output | 6 | Address of the word now driving `ctrl_o` |

## Verification
Branch decisions use the inputs present while the deciding word is active. The checks therefore assume that `opcode_i` and `ind_i` already describe the incoming instruction during the last fetch step, and that they hold steady until dispatch. The stimulus changes them only while the first fetch word is active. The interrupt request and the flags are redrawn every clock, so the checks also confirm that they are ignored outside the steps that test them.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CTRL_W = 16;
  localparam int AW     = 6;
  localparam int OPW    = 4;
  localparam int DEPTH  = 1 << AW;

  localparam logic [CTRL_W-1:0] L_PC_MAR    = CTRL_W'(1) << 0;
  localparam logic [CTRL_W-1:0] L_MEM_MBR   = CTRL_W'(1) << 1;
  localparam logic [CTRL_W-1:0] L_PC_INC    = CTRL_W'(1) << 2;
  localparam logic [CTRL_W-1:0] L_MBR_IR    = CTRL_W'(1) << 3;
  localparam logic [CTRL_W-1:0] L_IRA_MAR   = CTRL_W'(1) << 4;
  localparam logic [CTRL_W-1:0] L_MBRA_IRA  = CTRL_W'(1) << 5;
  localparam logic [CTRL_W-1:0] L_PC_MBR    = CTRL_W'(1) << 6;
  localparam logic [CTRL_W-1:0] L_SAVE_MAR  = CTRL_W'(1) << 7;
  localparam logic [CTRL_W-1:0] L_VEC_PC    = CTRL_W'(1) << 8;
  localparam logic [CTRL_W-1:0] L_MBR_MEM   = CTRL_W'(1) << 9;
  localparam logic [CTRL_W-1:0] L_BUS_RD    = CTRL_W'(1) << 10;
  localparam logic [CTRL_W-1:0] L_BUS_WR    = CTRL_W'(1) << 11;
  localparam logic [CTRL_W-1:0] L_ACC_ADD   = CTRL_W'(1) << 12;
  localparam logic [CTRL_W-1:0] L_ACC_LD    = CTRL_W'(1) << 13;
  localparam logic [CTRL_W-1:0] L_ACC_MBR   = CTRL_W'(1) << 14;
  localparam logic [CTRL_W-1:0] L_IRA_PC    = CTRL_W'(1) << 15;

  typedef enum logic [2:0] {
    C_JUMP  = 3'd0,
    C_SEQ   = 3'd1,
    C_ZERO  = 3'd2,
    C_NEG   = 3'd3,
    C_CARRY = 3'd4,
    C_IND   = 3'd5,
    C_IRQ   = 3'd6,
    C_DISP  = 3'd7
  } cond_e;

  typedef struct packed {
    logic [CTRL_W-1:0] lines;
    cond_e             cond;
    logic [AW-1:0]     tgt;
  } uword_t;

  localparam logic [AW-1:0] A_FETCH = AW'(0);
  localparam logic [AW-1:0] A_IND   = AW'(4);
  localparam logic [AW-1:0] A_INTR  = AW'(8);
  localparam logic [AW-1:0] A_NOP   = AW'(12);
  localparam logic [AW-1:0] A_UND   = AW'(14);
  localparam logic [AW-1:0] A_LOAD  = AW'(16);
  localparam logic [AW-1:0] A_ADD   = AW'(20);
  localparam logic [AW-1:0] A_STORE = AW'(24);
  localparam logic [AW-1:0] A_JMP   = AW'(28);
  localparam logic [AW-1:0] A_JZ    = AW'(30);
  localparam logic [AW-1:0] A_JN    = AW'(34);
  localparam logic [AW-1:0] A_JC    = AW'(38);
endpackage

// File: rtl/useq_decoder.sv
module useq_decoder
  import useq_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  start
);
  always_comb begin
    case (opcode)
      OPW'(0): start = A_NOP;
      OPW'(1): start = A_LOAD;
      OPW'(2): start = A_ADD;
      OPW'(3): start = A_STORE;
      OPW'(4): start = A_JMP;
      OPW'(5): start = A_JZ;
      OPW'(6): start = A_JN;
      OPW'(7): start = A_JC;
      default: start = A_UND;
    endcase
  end
endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  function automatic uword_t mk(logic [CTRL_W-1:0] l, cond_e c, logic [AW-1:0] t);
    uword_t u;
    u.lines = l;
    u.cond  = c;
    u.tgt   = t;
    return u;
  endfunction

  function automatic uword_t content(logic [AW-1:0] a);
    case (a)
      A_FETCH:       return mk(L_PC_MAR, C_SEQ, A_FETCH);
      A_FETCH+AW'(1): return mk(L_MEM_MBR | L_BUS_RD | L_PC_INC, C_SEQ, A_FETCH);
      A_FETCH+AW'(2): return mk(L_MBR_IR, C_IND, A_FETCH);
      A_IND:         return mk(L_IRA_MAR, C_SEQ, A_FETCH);
      A_IND+AW'(1):  return mk(L_MEM_MBR | L_BUS_RD, C_SEQ, A_FETCH);
      A_IND+AW'(2):  return mk(L_MBRA_IRA, C_DISP, A_FETCH);
      A_INTR:        return mk(L_PC_MBR, C_SEQ, A_FETCH);
      A_INTR+AW'(1): return mk(L_SAVE_MAR | L_VEC_PC, C_SEQ, A_FETCH);
      A_INTR+AW'(2): return mk(L_MBR_MEM | L_BUS_WR, C_JUMP, A_FETCH);
      A_NOP:         return mk('0, C_IRQ, A_FETCH);
      A_UND:         return mk('0, C_JUMP, A_FETCH);
      A_LOAD:        return mk(L_IRA_MAR, C_SEQ, A_FETCH);
      A_LOAD+AW'(1): return mk(L_MEM_MBR | L_BUS_RD, C_SEQ, A_FETCH);
      A_LOAD+AW'(2): return mk(L_ACC_LD, C_IRQ, A_FETCH);
      A_ADD:         return mk(L_IRA_MAR, C_SEQ, A_FETCH);
      A_ADD+AW'(1):  return mk(L_MEM_MBR | L_BUS_RD, C_SEQ, A_FETCH);
      A_ADD+AW'(2):  return mk(L_ACC_ADD, C_IRQ, A_FETCH);
      A_STORE:       return mk(L_IRA_MAR, C_SEQ, A_FETCH);
      A_STORE+AW'(1): return mk(L_ACC_MBR, C_SEQ, A_FETCH);
      A_STORE+AW'(2): return mk(L_MBR_MEM | L_BUS_WR, C_IRQ, A_FETCH);
      A_JMP:         return mk(L_IRA_PC, C_IRQ, A_FETCH);
      A_JZ:          return mk('0, C_ZERO, A_JZ + AW'(2));
      A_JZ+AW'(1):   return mk('0, C_IRQ, A_FETCH);
      A_JZ+AW'(2):   return mk(L_IRA_PC, C_IRQ, A_FETCH);
      A_JN:          return mk('0, C_NEG, A_JN + AW'(2));
      A_JN+AW'(1):   return mk('0, C_IRQ, A_FETCH);
      A_JN+AW'(2):   return mk(L_IRA_PC, C_IRQ, A_FETCH);
      A_JC:          return mk('0, C_CARRY, A_JC + AW'(2));
      A_JC+AW'(1):   return mk('0, C_IRQ, A_FETCH);
      A_JC+AW'(2):   return mk(L_IRA_PC, C_IRQ, A_FETCH);
      default:       return mk('0, C_JUMP, A_FETCH);
    endcase
  endfunction

  uword_t table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign table_q[i] = content(AW'(i));
  end

  assign word = table_q[addr];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  cond_e         cond,
  input  logic [AW-1:0] tgt,
  input  logic [AW-1:0] car,
  input  logic [AW-1:0] disp_addr,
  input  logic          ind,
  input  logic          irq,
  input  logic          zero,
  input  logic          neg,
  input  logic          carry,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] seq_addr;
  assign seq_addr = car + AW'(1);

  always_comb begin
    case (cond)
      C_JUMP:  nxt = tgt;
      C_SEQ:   nxt = seq_addr;
      C_ZERO:  nxt = zero  ? tgt : seq_addr;
      C_NEG:   nxt = neg   ? tgt : seq_addr;
      C_CARRY: nxt = carry ? tgt : seq_addr;
      C_IND:   nxt = ind   ? A_IND : disp_addr;
      C_IRQ:   nxt = irq   ? A_INTR : A_FETCH;
      C_DISP:  nxt = disp_addr;
      default: nxt = A_FETCH;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPW-1:0]    opcode_i,
  input  logic              ind_i,
  input  logic              irq_i,
  input  logic              zero_i,
  input  logic              neg_i,
  input  logic              carry_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [AW-1:0]     car_o
);
  logic [AW-1:0] car_q;
  uword_t        cbr_q;
  logic [AW-1:0] disp_addr;
  logic [AW-1:0] nxt_addr;
  uword_t        rom_word;

  useq_decoder u_dec (
    .opcode (opcode_i),
    .start  (disp_addr)
  );

  useq_next u_nxt (
    .cond      (cbr_q.cond),
    .tgt       (cbr_q.tgt),
    .car       (car_q),
    .disp_addr (disp_addr),
    .ind       (ind_i),
    .irq       (irq_i),
    .zero      (zero_i),
    .neg       (neg_i),
    .carry     (carry_i),
    .nxt       (nxt_addr)
  );

  useq_rom u_rom (
    .addr (nxt_addr),
    .word (rom_word)
  );

  // The reset word is all zero: its jump field points at fetch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= A_FETCH;
      cbr_q <= '0;
    end else begin
      car_q <= nxt_addr;
      cbr_q <= rom_word;
    end
  end

  assign ctrl_o = cbr_q.lines;
  assign car_o  = car_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ind_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [AW-1:0]     car_o
);
  p_rw_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_o[10] && ctrl_o[11]));

  p_fetch_step2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[0] |=> (ctrl_o[1] && ctrl_o[2] && ctrl_o[10]));

  p_fetch_step3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[2] |=> ctrl_o[3]);

  p_ind_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[3] && ind_i) |=> (car_o == A_IND && ctrl_o[4]));

  p_intr_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (car_o == A_INTR && ctrl_o[6]) |=> (ctrl_o[7] && ctrl_o[8]));

  p_intr_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[9] && ctrl_o[11] && car_o == A_INTR + AW'(2)) |=> (car_o == A_FETCH && ctrl_o[0]));

  p_undef_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (car_o == A_UND) |=> (car_o == A_FETCH && ctrl_o[0]));
endmodule

bind useq_sequencer useq_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ind_i  (ind_i),
  .ctrl_o (ctrl_o),
  .car_o  (car_o)
);

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic        ind_i = 1'b0, irq_i = 1'b0, zero_i = 1'b0, neg_i = 1'b0, carry_i = 1'b0;
  logic [15:0] ctrl_o;
  logic [5:0]  car_o;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  useq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .ind_i(ind_i), .irq_i(irq_i),
    .zero_i(zero_i), .neg_i(neg_i), .carry_i(carry_i), .ctrl_o(ctrl_o), .car_o(car_o)
  );

  localparam int S_RST = 0, S_F1 = 1, S_F2 = 2, S_F3 = 3, S_I1 = 4, S_I2 = 5, S_I3 = 6,
                 S_X1 = 7, S_X2 = 8, S_X3 = 9, S_NOP = 10, S_UND = 11, S_LD1 = 12,
                 S_LD2 = 13, S_LD3 = 14, S_AD1 = 15, S_AD2 = 16, S_AD3 = 17, S_ST1 = 18,
                 S_ST2 = 19, S_ST3 = 20, S_JMP = 21, S_JT = 22, S_JNT = 23, S_JTK = 24;

  function automatic logic [15:0] bits(int a, int b = -1, int c = -1);
    logic [15:0] v = '0;
    v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] exp_ctrl(int s);
    case (s)
      S_F1: return bits(0);
      S_F2: return bits(1, 2, 10);
      S_F3: return bits(3);
      S_I1, S_LD1, S_AD1, S_ST1: return bits(4);
      S_I2, S_LD2, S_AD2: return bits(1, 10);
      S_I3: return bits(5);
      S_X1: return bits(6);
      S_X2: return bits(7, 8);
      S_X3, S_ST3: return bits(9, 11);
      S_LD3: return bits(13);
      S_AD3: return bits(12);
      S_ST2: return bits(14);
      S_JMP, S_JTK: return bits(15);
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(int s);
    case (s)
      S_RST: return "R1";
      S_F1, S_F2, S_F3: return "R3";
      S_I1, S_I2, S_I3: return "R5";
      S_X1, S_X2, S_X3: return "R6";
      S_UND: return "R10";
      S_JT, S_JNT, S_JTK: return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic int dispatch(logic [3:0] op);
    case (op)
      4'd0: return S_NOP;
      4'd1: return S_LD1;
      4'd2: return S_AD1;
      4'd3: return S_ST1;
      4'd4: return S_JMP;
      4'd5, 4'd6, 4'd7: return S_JT;
      default: return S_UND;
    endcase
  endfunction

  function automatic int step(int s, logic [3:0] op, logic ind, logic irq,
                              logic z, logic n, logic c);
    case (s)
      S_RST: return S_F1;
      S_F1: return S_F2;
      S_F2: return S_F3;
      S_F3: return ind ? S_I1 : dispatch(op);   // R4
      S_I1: return S_I2;
      S_I2: return S_I3;
      S_I3: return dispatch(op);                // R5
      S_X1: return S_X2;
      S_X2: return S_X3;
      S_X3: return S_F1;
      S_UND: return S_F1;                       // R10 ignores irq
      S_LD1: return S_LD2;
      S_LD2: return S_LD3;
      S_AD1: return S_AD2;
      S_AD2: return S_AD3;
      S_ST1: return S_ST2;
      S_ST2: return S_ST3;
      S_JT: return ((op == 4'd5) ? z : (op == 4'd6) ? n : c) ? S_JTK : S_JNT;
      default: return irq ? S_X1 : S_F1;        // R7
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    int st;
    int inst;
    logic irq_hold;
    void'($urandom(32'd4711));
    st = S_RST;
    inst = 0;
    irq_hold = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", ctrl_o, 16'h0000);
    check("R1", {10'd0, car_o}, 16'd0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (st == S_F1 || st == S_RST) begin
        inst++;
        case (inst)
          1: begin opcode_i = 4'd1; ind_i = 1'b0; irq_hold = 1'b0; end
          2: begin opcode_i = 4'd2; ind_i = 1'b1; irq_hold = 1'b1; end
          3: begin opcode_i = 4'd9; ind_i = 1'b0; irq_hold = 1'b1; end
          4: begin opcode_i = 4'd5; ind_i = 1'b0; irq_hold = 1'b0; end
          5: begin opcode_i = 4'd6; ind_i = 1'b1; irq_hold = 1'b0; end
          6: begin opcode_i = 4'd0; ind_i = 1'b0; irq_hold = 1'b1; end
          7: begin opcode_i = 4'd15; ind_i = 1'b1; irq_hold = 1'b0; end
          8: begin opcode_i = 4'd3; ind_i = 1'b0; irq_hold = 1'b1; end
          default: begin
            opcode_i = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 2) != 0) opcode_i[3] = 1'b0;
            ind_i = ($urandom_range(0, 2) == 0);
          end
        endcase
      end
      if (inst <= 8) begin
        irq_i = irq_hold;
        zero_i = (inst == 4); neg_i = 1'b0; carry_i = ~zero_i;
      end else begin
        irq_i = ($urandom_range(0, 3) == 0);
        zero_i = 1'($urandom); neg_i = 1'($urandom); carry_i = 1'($urandom);
      end
      st = step(st, opcode_i, ind_i, irq_i, zero_i, neg_i, carry_i);
      @(posedge clk);
      @(negedge clk);
      check(req_of(st), ctrl_o, exp_ctrl(st));            // R2 bit map per step
      if (ctrl_o[10] && ctrl_o[11]) check("R11", ctrl_o & 16'h0C00, 16'h0400);
      if (st == S_F1) check("R3", {10'd0, car_o}, 16'd0);
      if (st == S_I1) check("R4", {10'd0, car_o}, 16'd4);
      if (st == S_X1) check("R6", {10'd0, car_o}, 16'd8);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule